// File: doc/BRIEF.md
# Prioritised Interrupt Processor Interface

This block sits between a bank of interrupt lines and one processor. It keeps an enable, a pending and an active bit for each of its lines, an 8-bit priority per line and a priority mask. From that state it drives a single interrupt request toward the processor. A line is passed on only when its priority value is strictly below the current threshold. The threshold is the smaller of the mask and the priority of the interrupt now being serviced.

The processor reads an acknowledge register to take the next interrupt. That read returns a line number, marks the line active and pushes the line's priority onto a running-priority stack, so nested preemption raises the bar for further requests. Writing a line number to the end-of-interrupt register retires the line and pops the stack. All configuration and status goes through a single-cycle word-addressed register port. Word offsets 0 to 7 hold the packed priorities, four lines per word. The enable, pending, active, mask, running-priority, acknowledge and end-of-interrupt words follow at offsets 8 to 14.

Top module: `irq_cpu_if`

## Requirements
- R1: A line is a candidate only if it is pending, enabled and not active; `irq_o` is low whenever there is no candidate.
- R2: `irq_o` is high exactly when some candidate has a priority value strictly less than min(mask, running priority). The mask is read and written at offset 11, bits 7:0.
- R3: A read of offset 13 returns, in bits 9:0, the lowest-numbered candidate, regardless of priority. On that edge the line becomes active, the stack index rises by one and the line's priority is stored at the new top.
- R4: On acknowledge, lines 0 to 15 also lose their pending bit, unless `irq_i` raises that same line in that cycle. Lines 16 and up keep theirs.
- R5: A write to offset 14 with a line number in bits 9:0 clears that line's active bit. It lowers the stack index by one only when the index is above zero.
- R6: An acknowledge with no candidate returns 1023 and changes no state.
- R7: After reset, every stack entry is 0xFF, the index is 0, and the mask, the enables, pending, active and priorities are all 0. `irq_o` and `err_o` are low.
- R8: Line n's priority is at bits 8*(n mod 4)+7 : 8*(n mod 4) of word n/4, for both reads and writes.
- R9: An acknowledge taken while the stack index is at STACK_DEPTH-1 sets the sticky `err_o` and leaves the stack untouched. It still marks the line active and returns its number.
- R10: The enable word (offset 8) is read/write. The pending word (offset 9) reads the pending bits, and writing a 1 clears the bit. The active word is offset 10 and read-only. A high `irq_i` bit sets pending, and a set wins over a clear in the same cycle. Offset 15 reads zero.
- R11: A read of offset 12 returns the stack entry at the current index in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 32 | Per-line raise strobes; a high bit sets that line pending |
| bus_valid_i | input | 1 | Register access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the current state |
| irq_o | output | 1 | Interrupt request to the processor |
| err_o | output | 1 | Sticky stack overflow flag |

## Verification
The bench first runs directed sequences. A mask set equal to a line's priority, then one above it, separates a strict comparison from a non-strict one. Nested acknowledges of decreasing priority values show that the running priority, not only the mask, gates the request. Acknowledging lines below and above 16 separates the edge-type pending clear from the retained one. A deep run of acknowledges with everything enabled exposes overflow handling and popping past zero. Long random mixes of priority, enable, mask and pending updates, with interleaved acknowledges and retires, then catch errors in the lowest-numbered selection and in byte-lane packing that the directed cases do not reach.

// File: rtl/irq_cpu_if.sv
module irq_cpu_if #(
  parameter int NUM_LINES   = 32,
  parameter int PRIO_W      = 8,
  parameter int STACK_DEPTH = 16,
  parameter int EDGE_LINES  = 16,
  parameter int ID_W        = 10,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 irq_o,
  output logic                 err_o
);
  localparam int PER_REG   = DATA_W / PRIO_W;
  localparam int PRIO_REGS = NUM_LINES / PER_REG;
  localparam int IDX_W     = $clog2(STACK_DEPTH);
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(PRIO_REGS);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PRIO_REGS + 1);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(PRIO_REGS + 2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(PRIO_REGS + 3);
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(PRIO_REGS + 4);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(PRIO_REGS + 5);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(PRIO_REGS + 6);
  localparam logic [ID_W-1:0]   SPURIOUS = '1;
  localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(STACK_DEPTH - 1);

  logic [PRIO_W-1:0]    prio [NUM_LINES];
  logic [PRIO_W-1:0]    stk  [STACK_DEPTH];
  logic [NUM_LINES-1:0] en_q, pend_q, act_q;
  logic [PRIO_W-1:0]    mask_q;
  logic [IDX_W-1:0]     sp_q;
  logic                 err_q;

  logic [NUM_LINES-1:0] cand;
  logic [PRIO_W-1:0]    run_prio, thr;
  logic                 any_cand, fwd;
  logic [LINE_W-1:0]    ack_line;

  wire wr     = bus_valid_i & bus_write_i;
  wire ack_rd = bus_valid_i & ~bus_write_i & (bus_addr_i == A_ACK);
  wire ack_hit = ack_rd & any_cand;
  wire eoi_wr = wr & (bus_addr_i == A_EOI);
  wire [ID_W-1:0] eoi_id = bus_wdata_i[ID_W-1:0];

  assign cand     = pend_q & en_q & ~act_q;
  assign any_cand = |cand;
  assign run_prio = stk[sp_q];
  assign thr      = (mask_q < run_prio) ? mask_q : run_prio;
  assign irq_o    = fwd;
  assign err_o    = err_q;

  always_comb begin
    fwd = 1'b0;
    for (int i = 0; i < NUM_LINES; i++)
      if (cand[i] && prio[i] < thr) fwd = 1'b1;
  end

  always_comb begin
    ack_line = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (cand[i]) ack_line = LINE_W'(i);
  end

  logic [NUM_LINES-1:0] pend_clr, act_set, act_clr;
  always_comb begin
    pend_clr = '0;
    act_set  = '0;
    act_clr  = '0;
    if (wr && bus_addr_i == A_PEND) pend_clr = bus_wdata_i[NUM_LINES-1:0];
    if (ack_hit) begin
      act_set[ack_line] = 1'b1;
      if (int'(ack_line) < EDGE_LINES) pend_clr[ack_line] = 1'b1;
    end
    if (eoi_wr && int'(eoi_id) < NUM_LINES) act_clr[eoi_id[LINE_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      mask_q <= '0;
      sp_q   <= '0;
      err_q  <= 1'b0;
      for (int i = 0; i < NUM_LINES; i++) prio[i] <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= '1;
    end else begin
      if (wr && int'(bus_addr_i) < PRIO_REGS)
        for (int k = 0; k < PER_REG; k++)
          prio[int'(bus_addr_i) * PER_REG + k] <= bus_wdata_i[k*PRIO_W +: PRIO_W];
      if (wr && bus_addr_i == A_EN)   en_q   <= bus_wdata_i[NUM_LINES-1:0];
      if (wr && bus_addr_i == A_MASK) mask_q <= bus_wdata_i[PRIO_W-1:0];
      pend_q <= (pend_q & ~pend_clr) | irq_i;
      act_q  <= (act_q | act_set) & ~act_clr;
      if (ack_hit) begin
        if (sp_q == TOP_IDX) err_q <= 1'b1;
        else begin
          sp_q <= sp_q + IDX_W'(1);
          stk[sp_q + IDX_W'(1)] <= prio[ack_line];
        end
      end
      if (eoi_wr && sp_q != '0) sp_q <= sp_q - IDX_W'(1);
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (int'(bus_addr_i) < PRIO_REGS) begin
      for (int k = 0; k < PER_REG; k++)
        bus_rdata_o[k*PRIO_W +: PRIO_W] = prio[int'(bus_addr_i) * PER_REG + k];
    end else begin
      case (bus_addr_i)
        A_EN:   bus_rdata_o[NUM_LINES-1:0] = en_q;
        A_PEND: bus_rdata_o[NUM_LINES-1:0] = pend_q;
        A_ACT:  bus_rdata_o[NUM_LINES-1:0] = act_q;
        A_MASK: bus_rdata_o[PRIO_W-1:0]    = mask_q;
        A_RUN:  bus_rdata_o[PRIO_W-1:0]    = run_prio;
        A_ACK:  bus_rdata_o[ID_W-1:0]      = any_cand ? ID_W'(ack_line) : SPURIOUS;
        default: bus_rdata_o = '0;
      endcase
    end
  end

  AST_NO_CAND_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !irq_o); // R1
  AST_MASK_ZERO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o); // R2
  AST_ACK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> act_q[$past(ack_line)]); // R3
  AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && int'(ack_line) < EDGE_LINES && !irq_i[ack_line]) |=> !pend_q[$past(ack_line)]); // R4
  AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && sp_q != '0) |=> sp_q == $past(sp_q) - IDX_W'(1)); // R5
  AST_SPURIOUS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !any_cand) |=> ($stable(act_q) && $stable(sp_q))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && sp_q == TOP_IDX) |=> (err_q && $stable(sp_q))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9
endmodule

// File: tb/sim_irq_cpu_if.sv
module sim_irq_cpu_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_i = '0;
  logic        bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, err_o;

  irq_cpu_if u0 (.clk, .rst_n, .irq_i, .bus_valid_i, .bus_write_i, .bus_addr_i,
                 .bus_wdata_i, .bus_rdata_o, .irq_o, .err_o);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]  m_prio [32];
  logic [7:0]  m_stk  [16];
  logic [31:0] m_en, m_pend, m_act;
  logic [7:0]  m_mask;
  int          m_idx;
  bit          m_err;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cand();
    return m_pend & m_en & ~m_act;
  endfunction

  function automatic bit exp_irq();
    logic [7:0] t = (m_mask < m_stk[m_idx]) ? m_mask : m_stk[m_idx];
    logic [31:0] c = cand();
    for (int i = 0; i < 32; i++) if (c[i] && m_prio[i] < t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int first_cand();
    logic [31:0] c = cand();
    for (int i = 0; i < 32; i++) if (c[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    int f;
    if (a < 8) return {m_prio[a*4+3], m_prio[a*4+2], m_prio[a*4+1], m_prio[a*4]};
    case (a)
      8: return m_en;
      9: return m_pend;
      10: return m_act;
      11: return {24'b0, m_mask};
      12: return {24'b0, m_stk[m_idx]};
      13: begin f = first_cand(); return (f < 0) ? 32'd1023 : 32'(f); end
      default: return 32'b0;
    endcase
  endfunction

  function automatic string rd_tag(logic [3:0] a);
    if (a < 8) return "R8";
    if (a == 11) return "R2";
    if (a == 12) return "R11";
    if (a == 13) return "R3";
    return "R10";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_prio[i] = 0;
    for (int i = 0; i < 16; i++) m_stk[i] = 8'hFF;
    m_en = 0; m_pend = 0; m_act = 0; m_mask = 0; m_idx = 0; m_err = 0;
  endtask

  task automatic model_apply(bit v, bit w, logic [3:0] a, logic [31:0] d, logic [31:0] lines);
    int f;
    if (v && w) begin
      if (a < 8) for (int k = 0; k < 4; k++) m_prio[a*4+k] = d[k*8 +: 8];
      else if (a == 8) m_en = d;
      else if (a == 9) m_pend = m_pend & ~d;
      else if (a == 11) m_mask = d[7:0];
      else if (a == 14) begin
        if (d[9:0] < 32) m_act[d[4:0]] = 1'b0;
        if (m_idx > 0) m_idx--;
      end
    end else if (v && a == 13) begin
      f = first_cand();
      if (f >= 0) begin
        m_act[f] = 1'b1;
        if (f < 16) m_pend[f] = 1'b0;
        if (m_idx == 15) m_err = 1;
        else begin m_idx++; m_stk[m_idx] = m_prio[f]; end
      end
    end
    m_pend = m_pend | lines;
  endtask

  task automatic step(bit v, bit w, logic [3:0] a, logic [31:0] d, logic [31:0] lines);
    @(negedge clk);
    chk("R1/R2 irq_o", {31'b0, irq_o}, {31'b0, exp_irq()});
    chk("R9 err_o", {31'b0, err_o}, {31'b0, m_err});
    bus_valid_i = v; bus_write_i = w; bus_addr_i = a; bus_wdata_i = d; irq_i = lines;
    #5;
    if (v && !w) chk(rd_tag(a), bus_rdata_o, exp_rd(a));
    @(posedge clk);
    #1;
    model_apply(v, w, a, d, lines);
    bus_valid_i = 0; bus_write_i = 0; irq_i = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d); step(1, 1, a, d, 0); endtask
  task automatic rd(logic [3:0] a); step(1, 0, a, 0, 0); endtask
  task automatic raise(logic [31:0] l); step(0, 0, 0, 0, l); endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R7 reset state
    rd(12); rd(11); rd(8); rd(9); rd(10); rd(0); rd(15);
    rd(13); // R6 spurious on empty
    // R8 packing
    wr(0, 32'h40302010); rd(0);
    wr(5, 32'h50504F50); rd(5);
    // R2 strict compare: line 20 prio 0x50
    wr(8, 32'h0070_0001); raise(32'h0010_0000);
    wr(11, 32'h50); raise(0);
    wr(11, 32'h51); raise(0);
    // R3 ack line 0 (prio 0x10) first; R4 edge clear
    raise(32'h0000_0001); rd(9); rd(13); rd(9); rd(12); rd(10);
    // R5 retire
    wr(14, 0); rd(12); rd(10);
    // running priority gating: ack line 20 then line 21 and 22
    wr(11, 32'hFF); rd(13); rd(12); rd(9);
    raise(32'h0060_0000); raise(0);
    rd(13); rd(12); wr(14, 22); wr(14, 20); rd(12);
    wr(9, 32'hFFFF_FFFF); rd(9);
    // R9 overflow: all lines, nest past the top
    wr(8, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) wr(4'(i), 32'h0);
    raise(32'hFFFF_FFFF);
    for (int i = 0; i < 18; i++) rd(13);
    rd(12); rd(10);
    for (int i = 0; i < 20; i++) wr(14, 32'(i));
    rd(12);
    wr(9, 32'hFFFF_FFFF); wr(14, 20); wr(14, 21); rd(13); rd(10);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      logic [31:0] lines = $urandom & $urandom & $urandom & $urandom;
      case (op)
        0: step(1, 0, 4'($urandom_range(0, 15)), 0, lines);
        1: step(1, 1, 4'($urandom_range(0, 7)), $urandom, lines);
        2: step(1, 1, 8, $urandom | $urandom, lines);
        3: step(1, 1, 11, 32'($urandom_range(0, 255)), lines);
        4, 5: step(1, 0, 13, 0, lines);
        6, 7: step(1, 1, 14, 32'($urandom_range(0, 40)), lines);
        8: step(1, 1, 9, $urandom & $urandom, lines);
        default: step(0, 0, 0, 0, lines);
      endcase
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule